// File: doc/BRIEF.md
# Oldest-First Issue Scheduler

This block is the instruction window of an out-of-order core. It holds renamed instructions. Each instruction carries two physical source tags, each of which can be flagged as an immediate, one physical destination tag and an identifier. Beside the window sits a ready table with one bit per physical register. An instruction becomes eligible once both of its non-immediate sources are marked ready. In each cycle the oldest eligible instruction, taken in the order of dispatch, leaves through the issue port. Issuing sets the destination's ready bit at the same edge, so a dependent instruction can issue in the next cycle. Execution is treated as taking a single cycle.

Rename drives dispatch as a valid/ready stream. A transfer happens only on an edge where `disp_valid` and `disp_ready` are both high. `disp_ready` falls while every slot is occupied or while flush is asserted. A source that holds `disp_valid` while `disp_ready` is low has nothing accepted. Rename clears the ready bit of each newly allocated destination through a separate clear port. Its restore path can set any bit through a set port. Flush drops every waiting instruction and leaves the ready table as rename left it. The issue port has no ready signal: an asserted `iss_valid` is a completed issue.

Top module: `issue_sched`

## Requirements
- R1: After reset every physical register is marked ready and the window is empty: `disp_ready`=1 and `iss_valid`=0.
- R2: An entry issues only when the ready bit of each of its non-immediate source tags is 1. An entry with a cleared source stays in the window.
- R3: When several entries are eligible in one cycle, the one dispatched earliest issues, whatever slot it occupies. At most one entry issues per cycle.
- R4: A younger entry whose sources are ready issues ahead of an older entry that is still waiting.
- R5: An issue sets the destination's ready bit at the edge that ends the issue cycle. An entry waiting only on that register can issue in the following cycle.
- R6: A pulse on `alloc_clr_valid` clears bit `alloc_clr_preg` at that edge. When a clear and a set name the same register at one edge, the clear wins.
- R7: A pulse on `restore_set_valid` sets bit `restore_set_preg` at that edge. An entry waiting on that register can issue in the next cycle.
- R8: A source whose immediate flag is 1 counts as ready whatever its table bit holds.
- R9: `disp_ready` is 0 while all slots hold entries, and a `disp_valid` seen in such a cycle is dropped. A slot freed by an issue can be refilled from the cycle after that issue.
- R10: In a cycle with `flush` high, `iss_valid` and `disp_ready` are 0. From the next cycle the window is empty, and the ready table is unchanged by the flush.
- R11: An entry accepted at an edge can issue at the earliest in the cycle after that edge. `iss_valid`, `iss_id` and `iss_dst` are presented in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch request |
| disp_ready | output | 1 | A free slot exists and no flush is active |
| disp_id | input | ID_W | Identifier carried to the issue port |
| disp_src1 | input | log2(PREGS) | First source physical tag |
| disp_src1_imm | input | 1 | First source is an immediate |
| disp_src2 | input | log2(PREGS) | Second source physical tag |
| disp_src2_imm | input | 1 | Second source is an immediate |
| disp_dst | input | log2(PREGS) | Destination physical tag |
| alloc_clr_valid | input | 1 | Clear one ready bit |
| alloc_clr_preg | input | log2(PREGS) | Register whose bit is cleared |
| restore_set_valid | input | 1 | Set one ready bit |
| restore_set_preg | input | log2(PREGS) | Register whose bit is set |
| flush | input | 1 | Empty the window |
| iss_valid | output | 1 | An entry issues this cycle |
| iss_id | output | ID_W | Identifier of the issuing entry |
| iss_dst | output | log2(PREGS) | Destination tag of the issuing entry |

## Verification
The issue outputs are combinational from registered state. After a dispatch handshake, the earliest issue is one cycle later. After a ready-bit change at an edge, whether from an issue or from the set port, a waiting dependent issues in the cycle after that edge. `disp_ready` rises in the cycle after the issue that freed the last slot. A flush takes effect in its own cycle and empties the window by the next one. The bench drives inputs just after the falling edge and checks outputs one time unit later, in the cycle where each result is due. A monitor at the rising edge logs every issued identifier with its cycle number, so the checks cover both the issue order and the gap of exactly one cycle between issues.

// File: rtl/sched_pkg.sv
package sched_pkg;
  // Per-bit update chosen for the ready table in a cycle.
  typedef enum logic [1:0] {
    RT_HOLD = 2'd0,
    RT_SET  = 2'd1,
    RT_CLR  = 2'd2
  } rt_op_e;

  localparam int DEF_ENTRIES = 4;
  localparam int DEF_PREGS   = 8;
  localparam int DEF_ID_W    = 4;
endpackage

// File: rtl/sched_ready_table.sv
module sched_ready_table
  import sched_pkg::*;
#(
  parameter int PREGS = DEF_PREGS,
  localparam int TAG_W = $clog2(PREGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_v,
  input  logic [TAG_W-1:0] clr_p,
  input  logic             set_a_v,
  input  logic [TAG_W-1:0] set_a_p,
  input  logic             set_b_v,
  input  logic [TAG_W-1:0] set_b_p,
  output logic [PREGS-1:0] rdy
);
  logic [PREGS-1:0] rdy_q;

  for (genvar g = 0; g < PREGS; g++) begin : g_bit
    rt_op_e op;
    always_comb begin
      if (clr_v && clr_p == TAG_W'(g))
        op = RT_CLR;
      else if ((set_a_v && set_a_p == TAG_W'(g)) ||
               (set_b_v && set_b_p == TAG_W'(g)))
        op = RT_SET;
      else
        op = RT_HOLD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rdy_q[g] <= 1'b1;
      end else begin
        case (op)
          RT_CLR:  rdy_q[g] <= 1'b0;
          RT_SET:  rdy_q[g] <= 1'b1;
          default: rdy_q[g] <= rdy_q[g];
        endcase
      end
    end
  end

  assign rdy = rdy_q;
endmodule

// File: rtl/sched_age_matrix.sv
module sched_age_matrix #(
  parameter int N = sched_pkg::DEF_ENTRIES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         alloc_v,
  input  logic [N-1:0] alloc_oh,
  input  logic [N-1:0] elig,
  output logic [N-1:0] grant
);
  // older_q[i][j] = 1 : entry i was written before entry j
  logic [N-1:0] older_q [N];
  logic [N-1:0] blocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) older_q[i] <= '0;
    end else if (alloc_v) begin
      for (int k = 0; k < N; k++) begin
        if (alloc_oh[k]) begin
          for (int j = 0; j < N; j++) begin
            if (j != k) begin
              older_q[k][j] <= 1'b0;
              older_q[j][k] <= 1'b1;
            end
          end
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      blocked[i] = 1'b0;
      for (int j = 0; j < N; j++) begin
        if (j != i && elig[j] && older_q[j][i]) blocked[i] = 1'b1;
      end
      grant[i] = elig[i] & ~blocked[i];
    end
  end
endmodule

// File: rtl/sched_slot_alloc.sv
module sched_slot_alloc #(
  parameter int N = sched_pkg::DEF_ENTRIES
) (
  input  logic [N-1:0] occ,
  output logic [N-1:0] free_oh,
  output logic         any_free
);
  logic found;

  always_comb begin
    free_oh = '0;
    found   = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!occ[i] && !found) begin
        free_oh[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  assign any_free = ~&occ;
endmodule

// File: rtl/issue_sched.sv
module issue_sched
  import sched_pkg::*;
#(
  parameter int ENTRIES = DEF_ENTRIES,
  parameter int PREGS   = DEF_PREGS,
  parameter int ID_W    = DEF_ID_W,
  localparam int TAG_W  = $clog2(PREGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             disp_valid,
  output logic             disp_ready,
  input  logic [ID_W-1:0]  disp_id,
  input  logic [TAG_W-1:0] disp_src1,
  input  logic             disp_src1_imm,
  input  logic [TAG_W-1:0] disp_src2,
  input  logic             disp_src2_imm,
  input  logic [TAG_W-1:0] disp_dst,
  input  logic             alloc_clr_valid,
  input  logic [TAG_W-1:0] alloc_clr_preg,
  input  logic             restore_set_valid,
  input  logic [TAG_W-1:0] restore_set_preg,
  input  logic             flush,
  output logic             iss_valid,
  output logic [ID_W-1:0]  iss_id,
  output logic [TAG_W-1:0] iss_dst
);
  typedef struct packed {
    logic [ID_W-1:0]  id;
    logic [TAG_W-1:0] s1;
    logic             i1;
    logic [TAG_W-1:0] s2;
    logic             i2;
    logic [TAG_W-1:0] dst;
  } ent_t;

  ent_t               ent_q [ENTRIES];
  logic [ENTRIES-1:0] ent_v;
  logic [ENTRIES-1:0] elig;
  logic [ENTRIES-1:0] grant;
  logic [ENTRIES-1:0] free_oh;
  logic               any_free;
  logic [PREGS-1:0]   rdy;
  logic               disp_fire;
  ent_t               disp_ent;

  assign disp_ready = any_free & ~flush;
  assign disp_fire  = disp_valid & disp_ready;
  assign disp_ent   = '{id: disp_id, s1: disp_src1, i1: disp_src1_imm,
                        s2: disp_src2, i2: disp_src2_imm, dst: disp_dst};

  sched_slot_alloc #(.N(ENTRIES)) u_alloc (
    .occ      (ent_v),
    .free_oh  (free_oh),
    .any_free (any_free)
  );

  sched_ready_table #(.PREGS(PREGS)) u_rt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_v   (alloc_clr_valid),
    .clr_p   (alloc_clr_preg),
    .set_a_v (iss_valid),
    .set_a_p (iss_dst),
    .set_b_v (restore_set_valid),
    .set_b_p (restore_set_preg),
    .rdy     (rdy)
  );

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    assign elig[e] = ent_v[e] &
                     (ent_q[e].i1 | rdy[ent_q[e].s1]) &
                     (ent_q[e].i2 | rdy[ent_q[e].s2]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ent_v[e] <= 1'b0;
      else if (flush)
        ent_v[e] <= 1'b0;
      else if (disp_fire && free_oh[e])
        ent_v[e] <= 1'b1;
      else if (grant[e])
        ent_v[e] <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (disp_fire && free_oh[e]) ent_q[e] <= disp_ent;
    end
  end

  sched_age_matrix #(.N(ENTRIES)) u_age (
    .clk      (clk),
    .rst_n    (rst_n),
    .alloc_v  (disp_fire),
    .alloc_oh (free_oh),
    .elig     (elig),
    .grant    (grant)
  );

  always_comb begin
    iss_id  = '0;
    iss_dst = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (grant[i]) begin
        iss_id  = iss_id  | ent_q[i].id;
        iss_dst = iss_dst | ent_q[i].dst;
      end
    end
  end

  assign iss_valid = (|grant) & ~flush;
endmodule

// File: rtl/issue_sched_chk.sv
module issue_sched_chk #(
  parameter int ENTRIES = sched_pkg::DEF_ENTRIES,
  parameter int PREGS   = sched_pkg::DEF_PREGS,
  localparam int TAG_W  = $clog2(PREGS)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               disp_ready,
  input logic               alloc_clr_valid,
  input logic [TAG_W-1:0]   alloc_clr_preg,
  input logic               restore_set_valid,
  input logic [TAG_W-1:0]   restore_set_preg,
  input logic               flush,
  input logic               iss_valid,
  input logic [TAG_W-1:0]   iss_dst,
  input logic [ENTRIES-1:0] ent_v,
  input logic [PREGS-1:0]   rdy
);
  AST_RESET_ALL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (&rdy) && (ent_v == '0)); // R1

  AST_NO_ISSUE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_v == '0) |-> !iss_valid); // R2

  AST_DST_READY_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && !(alloc_clr_valid && alloc_clr_preg == iss_dst)
    |=> rdy[$past(iss_dst)]); // R5

  AST_CLR_AT_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_clr_valid |=> !rdy[$past(alloc_clr_preg)]); // R6

  AST_RESTORE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    restore_set_valid && !(alloc_clr_valid && alloc_clr_preg == restore_set_preg)
    |=> rdy[$past(restore_set_preg)]); // R7

  AST_FULL_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
    (&ent_v) |-> !disp_ready); // R9

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (ent_v == '0) && !iss_valid); // R10

  AST_FLUSH_KEEPS_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
    flush && !alloc_clr_valid && !restore_set_valid |=> $stable(rdy)); // R10
endmodule

bind issue_sched issue_sched_chk #(.ENTRIES(ENTRIES), .PREGS(PREGS)) u_chk (.*);

// File: tb/test_issue_sched.sv
module test_issue_sched;
  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES = 4;
  localparam int PREGS   = 8;
  localparam int ID_W    = 4;
  localparam int TAG_W   = 3;

  logic             clk;
  logic             rst_n;
  logic             disp_valid;
  logic             disp_ready;
  logic [ID_W-1:0]  disp_id;
  logic [TAG_W-1:0] disp_src1;
  logic             disp_src1_imm;
  logic [TAG_W-1:0] disp_src2;
  logic             disp_src2_imm;
  logic [TAG_W-1:0] disp_dst;
  logic             alloc_clr_valid;
  logic [TAG_W-1:0] alloc_clr_preg;
  logic             restore_set_valid;
  logic [TAG_W-1:0] restore_set_preg;
  logic             flush;
  logic             iss_valid;
  logic [ID_W-1:0]  iss_id;
  logic [TAG_W-1:0] iss_dst;

  issue_sched #(.ENTRIES(ENTRIES), .PREGS(PREGS), .ID_W(ID_W)) i_issue_sched (
    .clk(clk), .rst_n(rst_n),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_id(disp_id),
    .disp_src1(disp_src1), .disp_src1_imm(disp_src1_imm),
    .disp_src2(disp_src2), .disp_src2_imm(disp_src2_imm), .disp_dst(disp_dst),
    .alloc_clr_valid(alloc_clr_valid), .alloc_clr_preg(alloc_clr_preg),
    .restore_set_valid(restore_set_valid), .restore_set_preg(restore_set_preg),
    .flush(flush),
    .iss_valid(iss_valid), .iss_id(iss_id), .iss_dst(iss_dst)
  );

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  int nlog = 0;
  int log_id [64];
  int log_cyc [64];
  int base;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (rst_n && iss_valid && nlog < 64) begin
      log_id[nlog]  = int'(iss_id);
      log_cyc[nlog] = cyc;
      nlog = nlog + 1;
    end
    cyc = cyc + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input bit dv, input int id, input int s1, input bit i1,
                       input int s2, input bit i2, input int d,
                       input bit cv, input int cp, input bit sv, input int sp,
                       input bit fl);
    @(negedge clk);
    disp_valid = dv;
    disp_id = ID_W'(id);
    disp_src1 = TAG_W'(s1); disp_src1_imm = i1;
    disp_src2 = TAG_W'(s2); disp_src2_imm = i2;
    disp_dst = TAG_W'(d);
    alloc_clr_valid = cv; alloc_clr_preg = TAG_W'(cp);
    restore_set_valid = sv; restore_set_preg = TAG_W'(sp);
    flush = fl;
    #1;
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic disp(input int id, input int s1, input bit i1,
                      input int s2, input bit i2, input int d);
    drive(1, id, s1, i1, s2, i2, d, 0, 0, 0, 0, 0);
    chk(disp_ready == 1'b1, "R9 dispatch accepted", int'(disp_ready), 1);
  endtask

  task automatic clr(input int p);
    drive(0, 0, 0, 0, 0, 0, 0, 1, p, 0, 0, 0);
  endtask

  task automatic setr(input int p);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, p, 0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    disp_valid = 0; disp_id = '0; disp_src1 = '0; disp_src1_imm = 0;
    disp_src2 = '0; disp_src2_imm = 0; disp_dst = '0;
    alloc_clr_valid = 0; alloc_clr_preg = '0;
    restore_set_valid = 0; restore_set_preg = '0; flush = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: empty window after reset
    chk(disp_ready == 1'b1, "R1 disp_ready after reset", int'(disp_ready), 1);
    chk(iss_valid == 1'b0, "R1 iss_valid after reset", int'(iss_valid), 0);

    // R1/R11: every register ready from reset; issue one cycle after dispatch
    for (int p = 0; p < PREGS; p++) begin
      disp(p, p, 0, PREGS - 1 - p, 0, p);
      idle();
      chk(iss_valid && int'(iss_id) == p, "R1 R11 issue with reset-ready sources",
          int'(iss_id), p);
      chk(int'(iss_dst) == p, "R11 issue destination", int'(iss_dst), p);
    end

    // R4/R2/R7: younger independent issues first; older waits for restore
    idle();
    base = nlog;
    clr(5);
    disp(2, 5, 0, 0, 0, 2);
    disp(3, 0, 0, 0, 1, 3);
    idle();
    chk(iss_valid && iss_id == 4'd3, "R4 younger independent issues", int'(iss_id), 3);
    idle(); idle();
    chk(nlog == base + 1, "R2 entry with cleared source waits", nlog - base, 1);
    setr(5);
    idle();
    chk(iss_valid && iss_id == 4'd2, "R7 restore set wakes entry", int'(iss_id), 2);
    idle();

    // R5: wakeup through the issue of a producer
    base = nlog;
    clr(6); clr(4);
    disp(4, 6, 0, 0, 1, 4);
    disp(5, 4, 0, 0, 1, 3);
    idle(); idle();
    chk(nlog == base, "R2 chain stalls before release", nlog - base, 0);
    setr(6);
    idle(); idle(); idle();
    chk(nlog == base + 2, "R5 both chain entries issued", nlog - base, 2);
    chk(log_id[base] == 4 && log_id[base+1] == 5, "R5 producer then dependent",
        log_id[base+1], 5);
    chk(log_cyc[base+1] - log_cyc[base] == 1, "R5 dependent one cycle after producer",
        log_cyc[base+1] - log_cyc[base], 1);

    // R3: age order differs from slot order (6 slot0, 8 slot2, 9 slot1)
    base = nlog;
    clr(6);
    disp(6, 6, 0, 0, 1, 1);
    disp(7, 0, 0, 0, 1, 2);
    disp(8, 6, 0, 0, 1, 3);
    idle();
    disp(9, 6, 0, 0, 1, 4);
    idle();
    setr(6);
    repeat (5) idle();
    chk(nlog == base + 4, "R3 all four issued", nlog - base, 4);
    chk(log_id[base] == 7, "R4 ready entry first", log_id[base], 7);
    chk(log_id[base+1] == 6, "R3 oldest waiting first", log_id[base+1], 6);
    chk(log_id[base+2] == 8, "R3 second oldest next", log_id[base+2], 8);
    chk(log_id[base+3] == 9, "R3 youngest last despite lower slot", log_id[base+3], 9);
    chk(log_cyc[base+3] - log_cyc[base+1] == 2, "R3 one issue per cycle",
        log_cyc[base+3] - log_cyc[base+1], 2);

    // R8: immediate flags over both sources cleared; issue iff both immediate
    base = nlog;
    clr(3);
    for (int k = 0; k < 4; k++) begin
      disp(k, 3, k[0], 3, k[1], 5);
      idle();
      chk(iss_valid == (k == 3), "R8 immediate bypasses table", int'(iss_valid),
          int'(k == 3));
    end
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    idle();
    chk(disp_ready == 1'b1, "R10 window empty after flush", int'(disp_ready), 1);
    setr(3);
    idle(); idle();
    chk(nlog == base + 1, "R10 flushed entries never issue", nlog - base, 1);

    // R6: clear beats set on the same register
    base = nlog;
    drive(0, 0, 0, 0, 0, 0, 0, 1, 2, 1, 2, 0);
    disp(8, 2, 0, 0, 0, 5);
    idle(); idle();
    chk(nlog == base, "R6 clear wins over set", nlog - base, 0);
    setr(2);
    idle();
    chk(iss_valid && iss_id == 4'd8, "R6 later set releases entry", int'(iss_id), 8);
    idle();

    // R9: full window back-pressure, dropped request, refill timing
    base = nlog;
    clr(6);
    for (int k = 0; k < ENTRIES; k++) disp(10 + k, 6, 0, 0, 1, 1 + k);
    idle();
    chk(disp_ready == 1'b0, "R9 disp_ready low when full", int'(disp_ready), 0);
    drive(1, 14, 0, 1, 0, 1, 5, 0, 0, 0, 0, 0);
    chk(disp_ready == 1'b0, "R9 request while full not accepted", int'(disp_ready), 0);
    idle();
    chk(iss_valid == 1'b0, "R2 full window all waiting", int'(iss_valid), 0);
    setr(6);
    idle();
    chk(iss_valid && iss_id == 4'd10, "R3 oldest of full window", int'(iss_id), 10);
    chk(disp_ready == 1'b0, "R9 still full in issue cycle", int'(disp_ready), 0);
    idle();
    chk(disp_ready == 1'b1, "R9 freed slot usable next cycle", int'(disp_ready), 1);
    idle(); idle(); idle();
    chk(nlog == base + ENTRIES, "R9 dropped request never issues", nlog - base, ENTRIES);
    for (int k = 0; k < ENTRIES; k++)
      chk(log_id[base+k] == 10 + k, "R3 full window drains in age order",
          log_id[base+k], 10 + k);

    // R10: flush suppresses issue and dispatch, keeps the ready table
    base = nlog;
    clr(6);
    disp(5, 6, 0, 0, 1, 1);
    disp(6, 0, 0, 0, 1, 2);
    drive(1, 9, 0, 1, 0, 1, 3, 0, 0, 0, 0, 1);
    chk(iss_valid == 1'b0, "R10 no issue during flush", int'(iss_valid), 0);
    chk(disp_ready == 1'b0, "R10 no dispatch during flush", int'(disp_ready), 0);
    idle();
    chk(disp_ready == 1'b1 && iss_valid == 1'b0, "R10 empty after flush",
        int'(iss_valid), 0);
    disp(7, 6, 0, 0, 1, 4);
    idle(); idle(); idle();
    chk(nlog == base, "R10 table bit still cleared after flush", nlog - base, 0);
    setr(6);
    idle();
    chk(iss_valid && iss_id == 4'd7, "R10 only new entry issues", int'(iss_id), 7);
    idle();
    chk(nlog == base + 1, "R10 single issue after flush", nlog - base, 1);

    summary();
    $finish;
  end
endmodule